// File: doc/BRIEF.md
# Bit Scan and Zero-Count Unit

This integer execution unit takes one scalar operand from a general-purpose register and returns one of four bit-position results. Two are counts: leading zeros and trailing zeros. Two are scans: the index of the highest set bit and the index of the lowest set bit. Each result comes with a zero flag (ZF) and a carry flag (CF). The counts and the scans follow different flag rules. A count reports a zero source on CF and a zero result on ZF. A scan reports a zero source on ZF, and for a zero source it keeps the previous destination value.

The operand is first masked to 16, 32 or 64 bits, as a size select chooses. A feature-enable input picks between the newer count behaviour and the legacy behaviour. While it is low, each count opcode runs as the scan in the same direction. The result, the flags and a valid strobe are registered, and they appear one clock after the request strobe.

Top module: `bitscan_unit`

## Requirements
- R1: A leading-zero count (op 2'b00) of a nonzero operand returns the operand width minus one minus the highest set index. For example, 0x000f0000 at 32 bits gives 12.
- R2: A trailing-zero count (op 2'b01) of a nonzero operand returns the index of the lowest set bit.
- R3: A reverse scan (op 2'b10) of a nonzero operand returns the highest set index. For 0x000f0000 it gives 19, so that the count and the scan add up to the width minus one.
- R4: A forward scan (op 2'b11) of a nonzero operand returns the index of the lowest set bit.
- R5: For a count with a zero operand, the result is the operand width, CF=1 and ZF=0. For a count with a nonzero operand, CF=0, and ZF=1 exactly when the count is zero.
- R6: For a scan with a zero operand, the result is the previous destination input unchanged, ZF=1 and CF=0. For a scan with a nonzero operand, ZF=0 and CF=0.
- R7: While the count-enable input is 0, op 2'b00 behaves as op 2'b10 and op 2'b01 behaves as op 2'b11. This covers the result and both flags.
- R8: The size select is 2'b00 for 16 bits, 2'b01 for 32 bits, and 2'b10 or 2'b11 for 64 bits. Operand bits at or above the selected width have no effect.
- R9: Every computed count or index is zero-extended, so all result bits above the 7-bit count field are zero.
- R10: The result, the flags and the valid strobe appear exactly one clock after a request. The valid strobe is high only in the cycle after a request. With no request, the result and the flags hold their values.
- R11: A synchronous active-high reset clears the valid strobe, the result and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation select |
| size_i | input | 2 | Operand size select |
| src_i | input | 64 | Source operand |
| prev_dst_i | input | 64 | Previous destination value |
| cnt_en_i | input | 1 | Count-behaviour enable |
| res_o | output | 64 | Registered result |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| vld_o | output | 1 | Result valid strobe |

## Verification
The bench aims at the edges of the operand: a lone top bit, a lone bottom bit, an all-zero source, and set bits that lie just above the selected width. A design that confused the two flag conventions would raise ZF instead of CF on a zero count, or would overwrite the destination on a zero scan. A design that ignored the size select would count the stray upper bits. Vectors with the feature disabled catch a design that keeps returning counts, and idle cycles between requests catch a result that changes without a request.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [1:0] {
    OP_LZC  = 2'b00,
    OP_TZC  = 2'b01,
    OP_SREV = 2'b10,
    OP_SFWD = 2'b11
  } bsu_op_e;
endpackage

// File: rtl/bsu_mask.sv
module bsu_mask #(
  parameter int XLEN = 64,
  parameter int CW   = $clog2(XLEN) + 1
) (
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] src,
  output logic [XLEN-1:0] masked,
  output logic [CW-1:0]   width
);
  localparam logic [XLEN-1:0] MASK_Q = {{(XLEN-XLEN/4){1'b0}}, {(XLEN/4){1'b1}}};
  localparam logic [XLEN-1:0] MASK_H = {{(XLEN-XLEN/2){1'b0}}, {(XLEN/2){1'b1}}};

  always_comb begin
    case (size)
      2'b00: begin masked = src & MASK_Q; width = CW'(XLEN/4); end
      2'b01: begin masked = src & MASK_H; width = CW'(XLEN/2); end
      default: begin masked = src; width = CW'(XLEN); end
    endcase
  end
endmodule

// File: rtl/bsu_find.sv
module bsu_find #(
  parameter int W    = 64,
  parameter bit HIGH = 1'b1,
  parameter int IW   = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  assign found = |vec;

  generate
    if (HIGH) begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) if (vec[i]) idx = IW'(i);
      end
    end else begin : g_low
      always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) if (vec[i]) idx = IW'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic [1:0]      op_i,
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] prev_dst_i,
  input  logic            cnt_en_i,
  output logic [XLEN-1:0] res_o,
  output logic            zf_o,
  output logic            cf_o,
  output logic            vld_o
);
  import bsu_pkg::*;

  localparam int IW = $clog2(XLEN);
  localparam int CW = IW + 1;

  logic [XLEN-1:0] opnd;
  logic [CW-1:0]   width;
  logic [IW-1:0]   hi_idx, lo_idx;
  logic            hi_found, lo_found;
  bsu_op_e         eff_op;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] n_res;
  logic            n_zf, n_cf;

  bsu_mask #(.XLEN(XLEN), .CW(CW)) u_mask (
    .size(size_i), .src(src_i), .masked(opnd), .width(width)
  );

  bsu_find #(.W(XLEN), .HIGH(1'b1), .IW(IW)) u_hi (
    .vec(opnd), .idx(hi_idx), .found(hi_found)
  );

  bsu_find #(.W(XLEN), .HIGH(1'b0), .IW(IW)) u_lo (
    .vec(opnd), .idx(lo_idx), .found(lo_found)
  );

  // legacy mode: count opcodes map onto the scan in the same direction
  assign eff_op = cnt_en_i ? bsu_op_e'(op_i) : bsu_op_e'({1'b1, op_i[0]});

  always_comb begin
    cnt   = '0;
    n_res = '0;
    n_zf  = 1'b0;
    n_cf  = 1'b0;
    case (eff_op)
      OP_LZC, OP_TZC: begin
        if (!hi_found) begin
          n_res = {{(XLEN-CW){1'b0}}, width};
          n_cf  = 1'b1;
        end else begin
          cnt   = (eff_op == OP_LZC) ? (width - CW'(1) - {1'b0, hi_idx})
                                     : {1'b0, lo_idx};
          n_res = {{(XLEN-CW){1'b0}}, cnt};
          n_zf  = (cnt == '0);
        end
      end
      default: begin
        if (!lo_found) begin
          n_res = prev_dst_i;
          n_zf  = 1'b1;
        end else begin
          n_res = {{(XLEN-IW){1'b0}}, (eff_op == OP_SREV) ? hi_idx : lo_idx};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      res_o <= '0;
      zf_o  <= 1'b0;
      cf_o  <= 1'b0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        res_o <= n_res;
        zf_o  <= n_zf;
        cf_o  <= n_cf;
      end
    end
  end

  assert_vld_after_req_R10: assert property (@(posedge clk) disable iff (rst)
    req_i |=> vld_o);
  assert_no_vld_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !vld_o);
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> ($stable(res_o) && $stable(zf_o) && $stable(cf_o)));
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> !(zf_o && cf_o));
  assert_cf_width_R5: assert property (@(posedge clk) disable iff (rst)
    (vld_o && cf_o) |-> (res_o == XLEN'(XLEN/4) || res_o == XLEN'(XLEN/2)
                         || res_o == XLEN'(XLEN)));
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (vld_o && !zf_o) |-> (res_o[XLEN-1:CW] == '0));
endmodule

// File: tb/tb_bitscan_unit.sv
`timescale 1ns/1ps
module tb_bitscan_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_i;
  logic [1:0]  op_i;
  logic [1:0]  size_i;
  logic [63:0] src_i;
  logic [63:0] prev_dst_i;
  logic        cnt_en_i;
  logic [63:0] res_o;
  logic        zf_o, cf_o, vld_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [63:0] exp_res = '0;
  logic        exp_zf = 1'b0, exp_cf = 1'b0, exp_vld = 1'b0;
  string       exp_tag = "R11";

  always #2 clk = ~clk;

  bitscan_unit dut (
    .clk(clk), .rst(rst), .req_i(req_i), .op_i(op_i), .size_i(size_i),
    .src_i(src_i), .prev_dst_i(prev_dst_i), .cnt_en_i(cnt_en_i),
    .res_o(res_o), .zf_o(zf_o), .cf_o(cf_o), .vld_o(vld_o)
  );

  // behavioural reference: returns {zf, cf, result}
  function automatic logic [65:0] ref_calc(input logic [1:0] op, input logic [1:0] sz,
      input logic [63:0] src, input logic [63:0] prev, input logic en);
    int w, hi, lo, e;
    logic [63:0] r;
    logic z, c;
    w  = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
    hi = -1;
    lo = -1;
    for (int i = 0; i < w; i++) if (src[i]) begin hi = i; if (lo < 0) lo = i; end
    e = en ? int'(op) : (2 + int'(op[0]));
    z = 1'b0;
    c = 1'b0;
    if (e < 2) begin
      if (hi < 0) begin r = 64'(w); c = 1'b1; end
      else begin r = (e == 0) ? 64'(w - 1 - hi) : 64'(lo); z = (r == 0); end
    end else begin
      if (hi < 0) begin r = prev; z = 1'b1; end
      else r = (e == 2) ? 64'(hi) : 64'(lo);
    end
    return {z, c, r};
  endfunction

  task automatic compare();
    vectors++;
    if (vld_o !== exp_vld || res_o !== exp_res || zf_o !== exp_zf || cf_o !== exp_cf) begin
      miscompares++;
      $display("FAIL %s: got vld=%0b res=%h zf=%0b cf=%0b, expected vld=%0b res=%h zf=%0b cf=%0b",
               exp_tag, vld_o, res_o, zf_o, cf_o, exp_vld, exp_res, exp_zf, exp_cf);
    end
  endtask

  task automatic step(input logic r, input logic q, input logic [1:0] op, input logic [1:0] sz,
                      input logic [63:0] src, input logic [63:0] prev, input logic en,
                      input string tag);
    logic [65:0] x;
    @(negedge clk);
    compare();
    rst = r; req_i = q; op_i = op; size_i = sz; src_i = src; prev_dst_i = prev; cnt_en_i = en;
    if (r) begin
      exp_vld = 1'b0; exp_res = '0; exp_zf = 1'b0; exp_cf = 1'b0;
    end else begin
      exp_vld = q;
      if (q) begin
        x = ref_calc(op, sz, src, prev, en);
        exp_zf = x[65]; exp_cf = x[64]; exp_res = x[63:0];
      end
    end
    exp_tag = tag;
  endtask

  initial begin
    rst = 1'b1; req_i = 1'b0; op_i = '0; size_i = '0; src_i = '0; prev_dst_i = '0; cnt_en_i = 1'b1;
    repeat (3) step(1, 1, 2'd0, 2'd2, 64'hFF, 64'h0, 1, "R11");
    step(0, 1, 2'd0, 2'd1, 64'h000f0000, 64'h0, 1, "R1");
    step(0, 1, 2'd2, 2'd1, 64'h000f0000, 64'h0, 1, "R3");
    step(0, 1, 2'd0, 2'd2, 64'h000f0000, 64'h0, 1, "R1");
    step(0, 1, 2'd0, 2'd0, 64'h8000, 64'h0, 1, "R5");
    step(0, 1, 2'd0, 2'd1, 64'h0, 64'h1234, 1, "R5");
    step(0, 1, 2'd1, 2'd2, 64'h0, 64'h1234, 1, "R5");
    step(0, 1, 2'd1, 2'd0, 64'h0001, 64'h0, 1, "R5");
    step(0, 1, 2'd1, 2'd1, 64'h00000100, 64'h0, 1, "R2");
    step(0, 1, 2'd3, 2'd2, 64'h8000000000000000, 64'h0, 1, "R4");
    step(0, 1, 2'd2, 2'd0, 64'h0, 64'hDEADBEEFCAFEF00D, 1, "R6");
    step(0, 1, 2'd3, 2'd3, 64'h0, 64'h0123456789ABCDEF, 1, "R6");
    step(0, 1, 2'd0, 2'd1, 64'h000f0000, 64'h0, 0, "R7");
    step(0, 1, 2'd1, 2'd1, 64'h0, 64'hA5A5A5A5A5A5A5A5, 0, "R7");
    step(0, 1, 2'd0, 2'd0, 64'hFFFF0000, 64'h0, 1, "R8");
    step(0, 1, 2'd1, 2'd1, 64'h100000000, 64'h0, 1, "R8");
    step(0, 1, 2'd3, 2'd0, 64'hFFFF_FFFF_FFFF_0000, 64'h77, 1, "R8");
    step(0, 1, 2'd2, 2'd2, 64'h1, 64'hFFFFFFFFFFFFFFFF, 1, "R9");
    step(0, 0, 2'd0, 2'd2, 64'h0, 64'h55, 1, "R10");
    step(0, 0, 2'd2, 2'd0, 64'h3, 64'h55, 1, "R10");
    step(0, 1, 2'd1, 2'd2, 64'h80, 64'h0, 1, "R10");
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] s;
      logic [1:0] op;
      s = {$urandom, $urandom};
      case ($urandom % 4)
        0: s = 64'h0;
        1: s = s >> ($urandom % 64);
        2: s = s << ($urandom % 64);
        default: ;
      endcase
      op = 2'($urandom % 4);
      step(0, 1'($urandom % 4 != 0), op, 2'($urandom % 4), s, {$urandom, $urandom},
           1'($urandom % 3 != 0),
           (op == 2'd0) ? "R1" : (op == 2'd1) ? "R2" : (op == 2'd2) ? "R3" : "R4");
    end
    step(1, 0, 2'd0, 2'd0, 64'h0, 64'h0, 1, "R11");
    step(0, 0, 2'd0, 2'd0, 64'h0, 64'h0, 1, "R11");
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no completion, expected completion within 100000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule